// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block gives a timer two input capture channels. Each channel watches one external pin for an edge of a chosen polarity. When that edge arrives, the channel copies the value of the free-running 8-bit counter into its own read-only data register. It also sets a capture flag and can raise an interrupt. The counter itself is outside the block, and its value arrives on an input port.

Software uses a small register bus with three byte-wide locations:

- **Offset 0:** a shared control/status byte. It holds the polarity select for each channel, the interrupt enable for each channel and the two capture flags.
- **Offset 1:** the channel 1 capture data register.
- **Offset 2:** the channel 2 capture data register.

A flag is cleared only by a strobed read of its own channel's data register. Writing to the flag positions does nothing. Both pins pass through a two-stage synchronizer before edge detection.

Top module: `tmr_capture_top`

## Requirements
- R1: After reset, all three register locations read 00h and no interrupt output is high.
- R2: Control byte layout:
  - Bit 4 is the channel 1 polarity and bit 5 is the channel 2 polarity. A 1 selects a rising edge and a 0 selects a falling edge.
  - Bit 2 is the channel 1 interrupt enable and bit 3 is the channel 2 interrupt enable.
  - Bits 7:6 always read 0, even after a write of FFh.
- R3: Control byte bit 0 is the channel 1 flag and bit 1 is the channel 2 flag. A write to offset 0 never changes either flag.
- R4: A channel captures only on an edge of its selected polarity. An edge of the other polarity leaves its flag and data unchanged.
- R5: On a capture, the channel's data register (offset 1 or 2) loads the counter value present in the cycle the synchronized edge is detected, and the channel's flag is set.
- R6: `irq_ch_o[n]` is high exactly when channel n's flag and enable are both set, and `irq_o` is the OR of both channels.
- R7: A read with `rd_i` high at offset 1 or 2 clears that channel's flag from the next cycle. The other channel's flag is untouched, and a read address presented without `rd_i` clears nothing.
- R8: If a capture and a strobed read of the same channel's data register fall in the same cycle, the capture wins: the register takes the new value and the flag stays set.
- R9: A second capture before the flag is cleared overwrites the data register with the newer counter value and keeps the flag set.
- R10: A pin change made between two clock edges sets the flag at the third following rising clock edge, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 8 | Free-running counter value |
| cap_in_i | input | 2 | External capture pins, bit 0 = channel 1 |
| addr_i | input | 2 | Register offset |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe, qualifies clear-on-read |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the current offset |
| irq_ch_o | output | 2 | Per-channel interrupt, bit 0 = channel 1 |
| irq_o | output | 1 | Combined interrupt |

## Verification
A flag stuck high or set by the wrong polarity appears at once on `irq_ch_o` and in bits 1:0 of offset 0. A data register loaded one cycle early or late shows a stale counter value on the very next read, because the bench changes the counter every cycle around the expected capture. A clear-on-read that loses to the read, or that reaches the wrong channel, appears in the flag bits one cycle after the strobed read.

// File: rtl/tmr_capture_pkg.sv
package tmr_capture_pkg;
  localparam int unsigned NCH   = 2;
  localparam int unsigned CNT_W = 8;
  localparam int unsigned ADR_W = 2;
  localparam logic [ADR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADR_W-1:0] ADR_CAP0 = 2'd1;
  localparam logic [ADR_W-1:0] ADR_CAP1 = 2'd2;
  // control byte field positions
  localparam int unsigned POL_LSB  = 4;
  localparam int unsigned IE_LSB   = 2;
  localparam int unsigned FLAG_LSB = 0;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic pol_i,
  output logic edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  always_comb begin
    if (pol_i) edge_o = s2_q & ~prev_q;
    else       edge_o = ~s2_q & prev_q;
  end
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [CNT_W-1:0] data_o,
  output logic             flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o <= '0;
      flag_o <= 1'b0;
    end else begin
      if (edge_i) data_o <= cnt_i;
      // capture has priority over clear-on-read
      if (edge_i)     flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cap_regif.sv
module cap_regif
  import tmr_capture_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADR_W-1:0]      addr_i,
  input  logic                  wr_i,
  input  logic                  rd_i,
  input  logic [7:0]            wdata_i,
  input  logic [NCH-1:0]        flag_i,
  input  logic [NCH*CNT_W-1:0]  cap_i,
  output logic [NCH-1:0]        pol_o,
  output logic [NCH-1:0]        ie_o,
  output logic [NCH-1:0]        clr_o,
  output logic [7:0]            rdata_o
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata_i[7:6], wdata_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o <= '0;
      ie_o  <= '0;
    end else if (wr_i && addr_i == ADR_CTRL) begin
      pol_o <= wdata_i[POL_LSB +: NCH];
      ie_o  <= wdata_i[IE_LSB +: NCH];
    end
  end

  assign clr_o[0] = rd_i && (addr_i == ADR_CAP0);
  assign clr_o[1] = rd_i && (addr_i == ADR_CAP1);

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADR_CTRL: begin
        rdata_o[POL_LSB +: NCH]  = pol_o;
        rdata_o[IE_LSB +: NCH]   = ie_o;
        rdata_o[FLAG_LSB +: NCH] = flag_i;
      end
      ADR_CAP0: rdata_o = cap_i[0 +: CNT_W];
      ADR_CAP1: rdata_o = cap_i[CNT_W +: CNT_W];
      default:  rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_capture_top.sv
module tmr_capture_top
  import tmr_capture_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [NCH-1:0]   cap_in_i,
  input  logic [ADR_W-1:0] addr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  output logic [NCH-1:0]   irq_ch_o,
  output logic             irq_o
);
  logic [NCH-1:0]       pol_w, ie_w, clr_w, edge_w, flag_w;
  logic [NCH*CNT_W-1:0] cap_flat_w;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    cap_edge_det u_edge (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .pin_i (cap_in_i[c]),
      .pol_i (pol_w[c]),
      .edge_o(edge_w[c])
    );
    cap_channel #(.CNT_W(CNT_W)) u_chan (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .edge_i(edge_w[c]),
      .clr_i (clr_w[c]),
      .cnt_i (cnt_i),
      .data_o(cap_flat_w[c*CNT_W +: CNT_W]),
      .flag_o(flag_w[c])
    );
  end

  cap_regif u_regif (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (addr_i),
    .wr_i   (wr_i),
    .rd_i   (rd_i),
    .wdata_i(wdata_i),
    .flag_i (flag_w),
    .cap_i  (cap_flat_w),
    .pol_o  (pol_w),
    .ie_o   (ie_w),
    .clr_o  (clr_w),
    .rdata_o(rdata_o)
  );

  assign irq_ch_o = flag_w & ie_w;
  assign irq_o    = |irq_ch_o;
endmodule

// File: rtl/tmr_capture_chk.sv
module tmr_capture_chk
  import tmr_capture_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [CNT_W-1:0]     cnt_i,
  input logic [ADR_W-1:0]     addr_i,
  input logic                 rd_i,
  input logic [NCH-1:0]       edge_w,
  input logic [NCH-1:0]       flag_w,
  input logic [NCH*CNT_W-1:0] cap_flat_w
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic clr_c;
    assign clr_c = rd_i && (addr_i == ADR_W'(c + 1));

    a_r5_capture_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(edge_w[c]) |-> (flag_w[c] && cap_flat_w[c*CNT_W +: CNT_W] == $past(cnt_i)));

    a_r7_clear_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(clr_c && !edge_w[c]) |-> !flag_w[c]);

    a_r3_flag_set_only_by_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag_w[c]) |-> $past(edge_w[c]));

    a_r9_data_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$past(edge_w[c]) |-> $stable(cap_flat_w[c*CNT_W +: CNT_W]));
  end
endmodule

bind tmr_capture_top tmr_capture_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cnt_i     (cnt_i),
  .addr_i    (addr_i),
  .rd_i      (rd_i),
  .edge_w    (edge_w),
  .flag_w    (flag_w),
  .cap_flat_w(cap_flat_w)
);

// File: tb/tmr_capture_top_tb_top.sv
module tmr_capture_top_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cnt_i = 8'h00;
  logic [1:0] cap_in_i = 2'b00;
  logic [1:0] addr_i = 2'd3;
  logic       wr_i = 1'b0, rd_i = 1'b0;
  logic [7:0] wdata_i = 8'h00;
  logic [7:0] rdata_o;
  logic [1:0] irq_ch_o;
  logic       irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  tmr_capture_top dut_i (.*);

  // {ch, pol, rise, cnt}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 1'b1, 1'b1, 8'h21}, {1'b0, 1'b1, 1'b0, 8'h42},
    {1'b0, 1'b0, 1'b0, 8'h63}, {1'b0, 1'b0, 1'b1, 8'h84},
    {1'b1, 1'b1, 1'b1, 8'hA5}, {1'b1, 1'b1, 1'b0, 8'hC6},
    {1'b1, 1'b0, 1'b0, 8'hE7}, {1'b1, 1'b0, 1'b1, 8'h08}
  };

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; addr_i = 2'd3;
  endtask

  // strobed read; value sampled before the clearing edge
  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a; rd_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_i = 1'b0; addr_i = 2'd3;
  endtask

  task automatic peek(logic [1:0] a, output logic [7:0] d);
    @(negedge clk_i);
    addr_i = a;
    #1 d = rdata_o;
  endtask

  // pin change, then counter = v exactly in the detection cycle
  task automatic pin(int ch, logic lvl, logic [7:0] v, logic coll_rd);
    @(negedge clk_i);
    cap_in_i[ch] = lvl; cnt_i = 8'hEE;
    @(posedge clk_i);
    @(posedge clk_i);
    @(negedge clk_i);
    cnt_i = v;
    if (coll_rd) begin addr_i = 2'(ch + 1); rd_i = 1'b1; end
    @(posedge clk_i);
    @(negedge clk_i);
    cnt_i = 8'h33; rd_i = 1'b0; addr_i = 2'd3;
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_i);
  endtask

  initial begin
    #2ms;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, prev;
    logic [1:0] a;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    for (int i = 0; i < 3; i++) begin
      a = 2'(i);
      peek(a, d); check("R1 reset rdata", d, 0);
    end
    check("R1 reset irq", {irq_ch_o, irq_o}, 0);
    rst_ni = 1'b1;
    settle();

    // R2 reserved bits
    wr(2'd0, 8'hFF);
    peek(2'd0, d); check("R2 ctrl readback", d, 8'h3C);

    // table: polarity / data / irq
    for (int i = 0; i < 8; i++) begin
      int ch;
      logic pol, rise, hit;
      logic [7:0] v;
      ch = int'(VEC[i][10]); pol = VEC[i][9]; rise = VEC[i][8]; v = VEC[i][7:0];
      hit = (pol == rise);
      wr(2'd0, {2'b00, 1'b0, 1'b0, 2'b11, 2'b00} | (8'(pol) << (4 + ch)));
      cap_in_i[ch] = ~rise;
      settle();
      rd(2'(ch + 1), prev);
      pin(ch, rise, v, 1'b0);
      peek(2'd0, d);
      check($sformatf("R4 flag vec%0d", i), d[ch], hit);
      check($sformatf("R6 irq_ch vec%0d", i), irq_ch_o[ch], hit);
      check($sformatf("R6 irq vec%0d", i), irq_o, hit);
      peek(2'(ch + 1), d);
      check($sformatf("R5 data vec%0d", i), d, hit ? v : prev);
      rd(2'(ch + 1), d);
    end

    // both channels rising, enables off
    wr(2'd0, 8'h30);
    cap_in_i = 2'b00; settle();
    rd(2'd1, d); rd(2'd2, d);
    pin(0, 1'b1, 8'h5A, 1'b0);
    check("R6 ie off irq", {irq_ch_o, irq_o}, 0);
    // R3 flag write ignored
    wr(2'd0, 8'h30);
    peek(2'd0, d); check("R3 write 0 to flag", d[1:0], 2'b01);
    wr(2'd0, 8'h33);
    peek(2'd0, d); check("R3 write 1 to flag", d[1:0], 2'b01);
    // R7 address without strobe, other channel read
    peek(2'd1, d); peek(2'd1, d);
    peek(2'd0, d); check("R7 no strobe no clear", d[0], 1);
    rd(2'd2, d);
    peek(2'd0, d); check("R7 other channel kept", d[0], 1);
    // R9 overwrite
    pin(0, 1'b0, 8'h11, 1'b0);
    pin(0, 1'b1, 8'h77, 1'b0);
    peek(2'd1, d); check("R9 overwrite data", d, 8'h77);
    peek(2'd0, d); check("R9 flag kept", d[0], 1);
    rd(2'd1, d);
    peek(2'd0, d); check("R7 cleared by read", d[0], 0);
    // R8 collision
    pin(0, 1'b0, 8'h10, 1'b0);
    pin(0, 1'b1, 8'h99, 1'b1);
    peek(2'd0, d); check("R8 flag wins", d[0], 1);
    peek(2'd1, d); check("R8 data new", d, 8'h99);
    rd(2'd1, d);
    // R10 latency, channel 2
    cap_in_i[1] = 1'b0; settle(); rd(2'd2, d);
    @(negedge clk_i); addr_i = 2'd0; cap_in_i[1] = 1'b1;
    @(negedge clk_i); check("R10 not after 1", rdata_o[1], 0);
    @(negedge clk_i); check("R10 not after 2", rdata_o[1], 0);
    @(negedge clk_i); check("R10 set after 3", rdata_o[1], 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule